// File: doc/BRIEF.md
# Trigger Algorithm Final Decision Logic

This block reduces a set of physics algorithm bits to one trigger decision per bunch-crossing clock. Each algorithm bit is built from the condition inputs by a small per-algorithm table: two selectable condition bits, each optionally inverted, are ANDed together. The algorithm bit then passes through its own prescaler, which lets through one of every N assertions. Accepted bits are counted per algorithm in saturating rate counters. The accepted bits that are enabled in the final-OR mask are ORed into the decision. Any raw algorithm bit whose veto flag is set suppresses that decision.

All per-algorithm settings sit in one configuration word per algorithm. A simple write port loads these words, and a read port returns either a configuration word or a rate counter. The logic never has to be rebuilt to retune the trigger. The latency from the condition inputs to the decision is a fixed two clocks for every configuration.

Top module: `trig_final_decision`

## Requirements
- R1: An algorithm's raw bit is `(cond[sel_a] ^ inv_a) & (cond[sel_b] ^ inv_b)`. The configuration word holds, from bit 0 upward: prescale (PS_W bits), mask (1), veto (1), sel_a (log2 N_COND), sel_b (log2 N_COND), inv_a (1) and inv_b (1).
- R2: With a prescale value N >= 1, an algorithm accepts the Nth, 2Nth, 3Nth ... assertion of its raw bit. N = 1 accepts every assertion.
- R3: A prescale value of 0 disables the algorithm. It never accepts and its counter never moves.
- R4: The decision is the OR of the accepted bits whose mask flag is 1.
- R5: If the raw bit of any algorithm whose veto flag is 1 is asserted, the decision for that crossing is 0. This holds whatever the prescale and mask of that algorithm are.
- R6: The accepted-bit vector and the decision appear on the outputs two clock edges after the condition inputs are sampled.
- R7: Each rate counter adds one per accepted bit and holds at its all-ones value.
- R8: A one-cycle `cnt_clr_i` strobe sets every counter to 0 at the next edge. The clear wins over an increment in the same cycle.
- R9: `rd_data_o` shows the configuration word of algorithm `rd_addr_i[IDX_W-1:0]` when `rd_addr_i[IDX_W]` is 0, and its counter when that bit is 1, zero-extended in both cases.
- R10: After reset the decision, the accepted bits, all configuration words and all counters are 0.
- R11: Writing an algorithm's configuration word restarts its prescale phase, so the next acceptance comes after N new assertions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cond_i | input | N_COND | Condition bits for this crossing |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | IDX_W | Algorithm index to write |
| wr_data_i | input | CFG_W | Configuration word |
| rd_addr_i | input | IDX_W+1 | Read select: top bit picks counter or config, low bits the algorithm |
| rd_data_o | output | DATA_W | Read data |
| cnt_clr_i | input | 1 | Synchronous clear of all rate counters |
| algo_pass_o | output | N_ALGO | Registered accepted bits |
| final_trig_o | output | 1 | Registered final decision |

## Verification
The checker tests these properties on every cycle:
- the decision is never 1 unless some accepted bit is 1;
- a vetoing raw bit forces the next decision low;
- an accepted bit never appears without a raw bit on the cycle before;
- a counter never wraps after saturation;
- a clear empties every counter.

Other behaviour needs directed sequences, which only the bench can supply. This covers the exact prescale phase (1-in-N counting and its restart on a write), the table's select and invert decoding, the count values reached, readback contents and the two-cycle alignment.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
  // Width of one configuration word for the given field widths
  function automatic int cfg_width(input int ps_w, input int sel_w);
    return ps_w + 2 + 2 * sel_w + 2;
  endfunction
endpackage

// File: rtl/tfd_rst_sync.sv
module tfd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tfd_algo_slot.sv
module tfd_algo_slot #(
  parameter int N_COND = 16,
  parameter int PS_W   = 8,
  parameter int SEL_W  = 4,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_COND-1:0] cond_i,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic             cnt_clr_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             algo_o,
  output logic             pass_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int MSK_B = PS_W;
  localparam int VET_B = PS_W + 1;
  localparam int SA_L  = PS_W + 2;
  localparam int SB_L  = SA_L + SEL_W;
  localparam int IA_B  = SB_L + SEL_W;
  localparam int IB_B  = IA_B + 1;

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             algo_q, algo_d;
  logic [PS_W-1:0]  ps_q, ps_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PS_W-1:0]  ps_val;
  logic [SEL_W-1:0] sel_a, sel_b;
  logic             hit;

  assign ps_val = cfg_q[PS_W-1:0];
  assign sel_a  = cfg_q[SA_L +: SEL_W];
  assign sel_b  = cfg_q[SB_L +: SEL_W];

  always_comb begin
    cfg_d  = wr_i ? wr_data_i : cfg_q;
    algo_d = (cond_i[sel_a] ^ cfg_q[IA_B]) & (cond_i[sel_b] ^ cfg_q[IB_B]);
    hit    = algo_q && (ps_val != '0) && (ps_q == ps_val - 1'b1);
    ps_d   = ps_q;
    if (wr_i)                            ps_d = '0;
    else if (algo_q && (ps_val != '0))   ps_d = hit ? '0 : ps_q + 1'b1;
    cnt_d  = cnt_q;
    if (cnt_clr_i)                       cnt_d = '0;
    else if (hit && (cnt_q != '1))       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      algo_q <= 1'b0;
      ps_q   <= '0;
      cnt_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      algo_q <= algo_d;
      ps_q   <= ps_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign algo_o = algo_q;
  assign pass_o = hit;
  assign cnt_o  = cnt_q;

  logic unused_msk;
  assign unused_msk = cfg_q[MSK_B] ^ cfg_q[VET_B];
endmodule

// File: rtl/tfd_final_or.sv
module tfd_final_or #(
  parameter int N_ALGO = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ALGO-1:0] pass_i,
  input  logic [N_ALGO-1:0] algo_i,
  input  logic [N_ALGO-1:0] mask_i,
  input  logic [N_ALGO-1:0] veto_i,
  output logic [N_ALGO-1:0] pass_o,
  output logic              final_o
);
  logic              fin_d, fin_q;
  logic [N_ALGO-1:0] pass_q;

  always_comb begin
    fin_d = (|(pass_i & mask_i)) & ~(|(algo_i & veto_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_q  <= 1'b0;
      pass_q <= '0;
    end else begin
      fin_q  <= fin_d;
      pass_q <= pass_i;
    end
  end

  assign final_o = fin_q;
  assign pass_o  = pass_q;
endmodule

// File: rtl/trig_final_decision.sv
module trig_final_decision #(
  parameter  int N_ALGO = 128,
  parameter  int N_COND = 16,
  parameter  int PS_W   = 8,
  parameter  int CNT_W  = 16,
  localparam int SEL_W  = $clog2(N_COND),
  localparam int CFG_W  = tfd_pkg::cfg_width(PS_W, SEL_W),
  localparam int IDX_W  = $clog2(N_ALGO),
  localparam int DATA_W = (CFG_W > CNT_W) ? CFG_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_COND-1:0] cond_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [CFG_W-1:0]  wr_data_i,
  input  logic [IDX_W:0]    rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              cnt_clr_i,
  output logic [N_ALGO-1:0] algo_pass_o,
  output logic              final_trig_o
);
  logic                           rst_sync_n;
  logic [N_ALGO-1:0][CFG_W-1:0]   cfg_all;
  logic [N_ALGO-1:0][CNT_W-1:0]   cnt_all;
  logic [N_ALGO-1:0]              algo_raw, pass_comb, mask_vec, veto_vec;
  logic [IDX_W-1:0]               rd_idx;

  tfd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  for (genvar g = 0; g < N_ALGO; g++) begin : g_slot
    logic wr_sel;
    assign wr_sel = wr_en_i && (wr_addr_i == IDX_W'(g));

    tfd_algo_slot #(
      .N_COND(N_COND), .PS_W(PS_W), .SEL_W(SEL_W), .CNT_W(CNT_W), .CFG_W(CFG_W)
    ) u_slot (
      .clk(clk), .rst_n(rst_sync_n), .cond_i(cond_i),
      .wr_i(wr_sel), .wr_data_i(wr_data_i), .cnt_clr_i(cnt_clr_i),
      .cfg_o(cfg_all[g]), .algo_o(algo_raw[g]), .pass_o(pass_comb[g]),
      .cnt_o(cnt_all[g])
    );

    assign mask_vec[g] = cfg_all[g][PS_W];
    assign veto_vec[g] = cfg_all[g][PS_W+1];
  end

  tfd_final_or #(.N_ALGO(N_ALGO)) u_or (
    .clk(clk), .rst_n(rst_sync_n),
    .pass_i(pass_comb), .algo_i(algo_raw), .mask_i(mask_vec), .veto_i(veto_vec),
    .pass_o(algo_pass_o), .final_o(final_trig_o)
  );

  assign rd_idx = rd_addr_i[IDX_W-1:0];

  always_comb begin
    if (rd_addr_i[IDX_W]) rd_data_o = DATA_W'(cnt_all[rd_idx]);
    else                  rd_data_o = DATA_W'(cfg_all[rd_idx]);
  end
endmodule

// File: rtl/tfd_checker.sv
module tfd_checker #(
  parameter int N_ALGO = 128,
  parameter int CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         final_trig,
  input logic [N_ALGO-1:0]            algo_pass,
  input logic [N_ALGO-1:0]            algo_raw,
  input logic [N_ALGO-1:0]            veto_vec,
  input logic [N_ALGO-1:0][CNT_W-1:0] cnt_all,
  input logic                         cnt_clr
);
  assert_final_needs_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    final_trig |-> (algo_pass != '0));

  assert_veto_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((algo_raw & veto_vec) != '0) |=> !final_trig);

  assert_pass_needs_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (algo_pass != '0) |-> ((algo_pass & ~$past(algo_raw)) == '0));

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_all == '0));

  for (genvar g = 0; g < N_ALGO; g++) begin : g_sat
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_all[g] == '1) && !cnt_clr) |=> (cnt_all[g] == '1));
  end
endmodule

bind trig_final_decision tfd_checker #(.N_ALGO(N_ALGO), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .final_trig(final_trig_o),
  .algo_pass(algo_pass_o), .algo_raw(algo_raw), .veto_vec(veto_vec),
  .cnt_all(cnt_all), .cnt_clr(cnt_clr_i)
);

// File: tb/trig_final_decision_bench.sv
`timescale 1ns/1ps
module trig_final_decision_bench;
  localparam int NA = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cond;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [13:0] wr_data;
  logic [3:0]  rd_addr;
  logic [13:0] rd_data;
  logic        cnt_clr;
  logic [7:0]  pass_o;
  logic        fin_o;

  always #2.5 clk = ~clk;

  trig_final_decision #(.N_ALGO(8), .N_COND(8), .PS_W(4), .CNT_W(4)) u_trig_final_decision (
    .clk(clk), .rst_n(rst_n), .cond_i(cond), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cnt_clr_i(cnt_clr), .algo_pass_o(pass_o), .final_trig_o(fin_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench-side model of the configuration and counters
  int   ps_m[NA], sa_m[NA], sb_m[NA], pc_m[NA], cnt_m[NA];
  logic msk_m[NA], vet_m[NA], ia_m[NA], ib_m[NA];

  typedef struct { int due; logic fin; logic [7:0] pass; string tag; } exp_t;
  exp_t sb_q[$];

  function automatic logic [13:0] pack(int ps, logic m, logic v, int sa, int sb, logic ia, logic ib);
    return {ib, ia, 3'(sb), 3'(sa), v, m, 4'(ps)};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // driver: one crossing; expected result is due two edges later (R6)
  task automatic step(logic [7:0] c, string tag);
    exp_t e;
    logic vh;
    e.pass = '0; vh = 1'b0;
    for (int i = 0; i < NA; i++) begin
      logic a;
      a = (c[sa_m[i]] ^ ia_m[i]) & (c[sb_m[i]] ^ ib_m[i]);   // R1
      vh |= a & vet_m[i];
      if (a && ps_m[i] != 0) begin
        if (pc_m[i] == ps_m[i] - 1) begin e.pass[i] = 1'b1; pc_m[i] = 0; end
        else pc_m[i]++;
      end
      if (e.pass[i] && cnt_m[i] < 15) cnt_m[i]++;
    end
    e.fin = 1'b0;
    for (int i = 0; i < NA; i++) if (e.pass[i] && msk_m[i]) e.fin = 1'b1;
    if (vh) e.fin = 1'b0;
    e.due = cyc + 2;
    e.tag = tag;
    sb_q.push_back(e);
    cond = c;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(8'h00, "R6");
  endtask

  task automatic cfg_wr(int idx, int ps, logic m, logic v, int sa, int sb, logic ia, logic ib);
    wr_en = 1'b1; wr_addr = 3'(idx); wr_data = pack(ps, m, v, sa, sb, ia, ib);
    @(negedge clk);
    wr_en = 1'b0;
    ps_m[idx] = ps; msk_m[idx] = m; vet_m[idx] = v;
    sa_m[idx] = sa; sb_m[idx] = sb; ia_m[idx] = ia; ib_m[idx] = ib;
    pc_m[idx] = 0;   // R11
  endtask

  task automatic rd_chk(logic [3:0] a, logic [13:0] exp, string tag);
    rd_addr = a;
    #1;
    check(tag, 32'(rd_data), 32'(exp));
  endtask

  // monitor: pops expected items when they fall due
  initial begin
    forever begin
      @(posedge clk); #1;
      while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " R4 decision"}, 32'(fin_o), 32'(e.fin));
        check({e.tag, " R2 accepted bits"}, 32'(pass_o), 32'(e.pass));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NA; i++) begin
      ps_m[i] = 0; sa_m[i] = 0; sb_m[i] = 0; pc_m[i] = 0; cnt_m[i] = 0;
      msk_m[i] = 0; vet_m[i] = 0; ia_m[i] = 0; ib_m[i] = 0;
    end
    rst_n = 1'b0; cond = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; cnt_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    check("R10 decision", 32'(fin_o), 0);
    check("R10 accepted", 32'(pass_o), 0);
    rd_chk(4'h3, 14'h0, "R10 config");
    rd_chk(4'hB, 14'h0, "R10 counter");

    cfg_wr(0, 1, 1, 0, 0, 1, 0, 0);   // c0 & c1, every assertion
    cfg_wr(1, 3, 1, 0, 2, 2, 0, 0);   // c2, one in three
    cfg_wr(2, 0, 1, 0, 3, 3, 0, 0);   // R3 disabled
    cfg_wr(3, 1, 0, 1, 4, 4, 0, 0);   // veto on c4, not masked
    cfg_wr(4, 1, 1, 0, 5, 6, 1, 0);   // ~c5 & c6
    rd_chk(4'h4, pack(1, 1, 0, 5, 6, 1, 0), "R9 config readback R1");

    step(8'h03, "R1 and");
    step(8'h13, "R5 veto");
    step(8'h40, "R1 invert");
    step(8'h60, "R1 invert blocked");
    step(8'h08, "R3 disabled");
    for (int i = 0; i < 4; i++) step(8'h04, "R2 one in three");
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[7:0], "R2 mixed");
    end
    drain();
    for (int i = 0; i < 5; i++) rd_chk(4'(8 + i), 14'(cnt_m[i]), "R9 counter");
    rd_chk(4'hA, 14'h0, "R3 counter stays zero");

    // R7 saturation
    for (int i = 0; i < 20; i++) step(8'h03, "R7");
    drain();
    rd_chk(4'h8, 14'hF, "R7 saturated counter");

    // R8 clear
    cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
    for (int i = 0; i < NA; i++) cnt_m[i] = 0;
    rd_chk(4'h8, 14'h0, "R8 cleared counter 0");
    rd_chk(4'hC, 14'h0, "R8 cleared counter 4");

    // R11 phase restart on write
    step(8'h04, "R11"); step(8'h04, "R11");
    drain();
    cfg_wr(1, 3, 1, 0, 2, 2, 0, 0);
    for (int i = 0; i < 3; i++) step(8'h04, "R11 restarted phase");
    drain();
    rd_chk(4'h9, 14'(cnt_m[1]), "R11 counter");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule